// File: doc/BRIEF.md
# DMA channel counting semaphore

This block is the counting semaphore attached to a single DMA channel. It keeps the processor's program stream and the channel's descriptor-chain engine in step. Software talks to it through a plain 32-bit write/read register. The value software writes into the low byte is added to an 8-bit count. A read returns that count in bits 23:16, and every other bit of the read value is zero.

The DMA engine asks to take one unit from the count by raising `dec_req`. It does this each time it finishes a descriptor that calls for semaphore handling. The request is granted in the same cycle whenever a unit is available. A unit is available when the count is nonzero, or when a software add lands on that same clock. If no unit is available, `dma_stall` is raised instead. The request then stays pending until software adds to the count, and the engine waits.

A software add and a granted decrement on the same clock merge into one net update. Additions that would go past the top of the count saturate there instead of wrapping.

Top module: `dma_sema_channel`

## Requirements
- R1: After reset the count is zero, so a read returns 0x0000_0000, and with `dec_req` low both `dec_gnt` and `dma_stall` are low.
- R2: `sw_rdata` always carries the current count in bits 23:16; bits 31:24, 15:8 and 7:0 always read as zero.
- R3: A write (`sw_wr_en` high) adds `sw_wdata[7:0]` to the count at the next clock edge; bits 31:8 of the write data have no effect.
- R4: A write whose bits 7:0 are zero leaves the count unchanged and does not release a stall: `dma_stall` stays high and `dec_gnt` stays low in that cycle.
- R5: When the add (less any same-clock decrement) would exceed 255, the count becomes 255 instead of wrapping.
- R6: While `dec_req` is high and the count is nonzero, `dec_gnt` is high in that same cycle, and the count is one lower after the clock edge, provided there is no add on that edge.
- R7: While `dec_req` is high, the count is zero and no nonzero add is presented, `dec_gnt` is low, `dma_stall` is high and the count stays at zero.
- R8: A nonzero add and a granted decrement on the same clock give a count of count + add − 1. This includes releasing a stalled request: `dec_gnt` rises and `dma_stall` falls in the cycle the write is presented.
- R9: `dec_gnt` is never high without `dec_req`; `dma_stall` equals `dec_req` and not `dec_gnt`, so the two are never high together.
- R10: A request held high gets one grant per clock cycle for as long as units last, then turns into a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_en | input | 1 | Software write strobe for the semaphore register |
| sw_wdata | input | 32 | Write data; bits 7:0 hold the amount to add |
| sw_rdata | output | 32 | Read data; count in bits 23:16, all other bits zero |
| dec_req | input | 1 | DMA engine asks to take one unit; held until granted |
| dec_gnt | output | 1 | One unit taken this cycle |
| dma_stall | output | 1 | Request pending with no unit available |

## Verification
The bench builds the block with its default parameters: an 8-bit count in a 32-bit register with the count field at bit 16. With those values the top of the count is only two 0xFF writes away, so saturation with and without a same-clock decrement can be reached directly. A full drain of 255 back-to-back grants into a stall also fits in a few hundred cycles. A pseudo-random phase mixes writes with upper-bit garbage, zero-valued adds and toggling requests. It compares grant, stall and read data against a behavioural model on every clock.

// File: rtl/sema_pkg.sv
package sema_pkg;
    localparam int unsigned REG_W   = 32;  // register width
    localparam int unsigned CNT_W   = 8;   // semaphore count width
    localparam int unsigned CNT_LSB = 16;  // read position of the count field
    localparam int unsigned INC_LSB = 0;   // write position of the add field
endpackage

// File: rtl/sema_regif.sv
module sema_regif
    import sema_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned CL = CNT_LSB,
    parameter int unsigned IL = INC_LSB
) (
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] add_amt,
    output logic          add_nz,
    output logic [DW-1:0] rdata
);
    localparam int unsigned IHI = IL + CW;

    // bits of the write word outside the add field carry no meaning
    logic unused_hi;
    if (IHI < DW) begin : g_hi
        assign unused_hi = ^wdata[DW-1:IHI];
    end else begin : g_nohi
        assign unused_hi = 1'b0;
    end

    always_comb begin
        add_amt = wr_en ? wdata[IL +: CW] : '0;
        add_nz  = (add_amt != '0);
    end

    always_comb begin
        rdata           = '0;
        rdata[CL +: CW] = count;
    end
endmodule

// File: rtl/sema_arbiter.sv
module sema_arbiter (
    input  logic req,
    input  logic count_nz,
    input  logic add_nz,
    output logic gnt,
    output logic stall
);
    logic unit_avail;

    always_comb begin
        unit_avail = count_nz | add_nz;
        gnt        = req & unit_avail;
        stall      = req & ~unit_avail;
    end
endmodule

// File: rtl/sema_update.sv
module sema_update
    import sema_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] add_amt,
    input  logic          take,
    output logic [CW-1:0] count_next
);
    logic [CW:0] wide;

    always_comb begin
        // a take is only granted when count+add >= 1, so this never underflows
        wide = {1'b0, count} + {1'b0, add_amt} - {{CW{1'b0}}, take};
        if (wide[CW]) begin
            count_next = '1;
        end else begin
            count_next = wide[CW-1:0];
        end
    end
endmodule

// File: rtl/dma_sema_channel.sv
module dma_sema_channel
    import sema_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned CL = CNT_LSB,
    parameter int unsigned IL = INC_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr_en,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] sw_rdata,
    input  logic          dec_req,
    output logic          dec_gnt,
    output logic          dma_stall
);
    typedef struct packed {
        logic [CW-1:0] count;
    } sema_state_t;

    sema_state_t   state_d, state_q;
    logic [CW-1:0] add_amt;
    logic          add_nz;
    logic [CW-1:0] count_next;

    sema_regif #(.DW(DW), .CW(CW), .CL(CL), .IL(IL)) u_regif (
        .wr_en   (sw_wr_en),
        .wdata   (sw_wdata),
        .count   (state_q.count),
        .add_amt (add_amt),
        .add_nz  (add_nz),
        .rdata   (sw_rdata)
    );

    sema_arbiter u_arb (
        .req      (dec_req),
        .count_nz (state_q.count != '0),
        .add_nz   (add_nz),
        .gnt      (dec_gnt),
        .stall    (dma_stall)
    );

    sema_update #(.CW(CW)) u_upd (
        .count      (state_q.count),
        .add_amt    (add_amt),
        .take       (dec_gnt),
        .count_next (count_next)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = count_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/sema_chk.sv
module sema_chk
    import sema_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned CL = CNT_LSB,
    parameter int unsigned IL = INC_LSB
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_wr_en,
    input logic [DW-1:0] sw_wdata,
    input logic [DW-1:0] sw_rdata,
    input logic          dec_req,
    input logic          dec_gnt,
    input logic          dma_stall
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] inc;
    logic          inc_nz;
    logic [CW+1:0] want;

    assign cnt    = sw_rdata[CL +: CW];
    assign inc    = sw_wr_en ? sw_wdata[IL +: CW] : '0;
    assign inc_nz = (inc != '0);
    assign want   = {2'b0, cnt} + {2'b0, inc} - {{(CW+1){1'b0}}, dec_gnt};

    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata & ~({{(DW-CW){1'b0}}, {CW{1'b1}}} << CL)) == '0); // R2

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dec_gnt |-> dec_req); // R9

    AST_REQ_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |-> (dec_gnt ^ dma_stall)); // R9

    AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_req |-> !dma_stall); // R9

    AST_ZERO_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && cnt == '0 && !inc_nz) |-> dma_stall); // R7

    AST_NONZERO_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && cnt != '0) |-> dec_gnt); // R6

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_gnt && !inc_nz) |=> cnt == CW'($past(cnt) - 1'b1)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_gnt && !inc_nz) |=> $stable(cnt)); // R4

    AST_NET_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_nz && want <= {2'b0, {CW{1'b1}}}) |=> cnt == $past(want[CW-1:0])); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_nz && want > {2'b0, {CW{1'b1}}}) |=> cnt == '1); // R5
endmodule

bind dma_sema_channel sema_chk #(.DW(DW), .CW(CW), .CL(CL), .IL(IL)) u_sema_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr_en  (sw_wr_en),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .dec_req   (dec_req),
    .dec_gnt   (dec_gnt),
    .dma_stall (dma_stall)
);

// File: tb/dma_sema_channel_test.sv
`timescale 1ns/1ps
module dma_sema_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        dec_req = 1'b0;
    logic        dec_gnt;
    logic        dma_stall;

    int tests = 0;
    int fails = 0;
    int ref_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_sema_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr_en  (sw_wr_en),
        .sw_wdata  (sw_wdata),
        .sw_rdata  (sw_rdata),
        .dec_req   (dec_req),
        .dec_gnt   (dec_gnt),
        .dma_stall (dma_stall)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check outputs, then advance the model at the rising edge
    task automatic step(input bit wr, input logic [31:0] data, input bit req, input string tag);
        int add;
        bit exp_g;
        bit exp_s;
        int nxt;
        @(negedge clk);
        sw_wr_en = wr;
        sw_wdata = data;
        dec_req  = req;
        add   = wr ? int'(data[7:0]) : 0;
        exp_g = req && (ref_cnt > 0 || add > 0);
        exp_s = req && !exp_g;
        #1;
        check(tag, "dec_gnt", dec_gnt, exp_g);
        check(tag, "dma_stall", dma_stall, exp_s);
        check(tag, "sw_rdata", sw_rdata, longint'(ref_cnt) << 16);
        @(posedge clk);
        nxt = ref_cnt + add - (exp_g ? 1 : 0);
        ref_cnt = (nxt > 255) ? 255 : nxt;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "sw_rdata", sw_rdata, 0);
        check("R1", "dec_gnt", dec_gnt, 0);
        check("R1", "dma_stall", dma_stall, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 32'h0, 0, "R1");
        // R7: request at zero stalls
        repeat (3) step(0, 32'h0, 1, "R7");
        // R4: zero-valued add, even with high garbage, keeps the stall
        step(1, 32'h0000_0000, 1, "R4");
        step(1, 32'hFFFF_FF00, 1, "R4");
        // R8: add of one releases the stall in the same cycle, net count 0
        step(1, 32'h0000_0001, 1, "R8");
        step(0, 32'h0, 0, "R8");
        // R3: upper write bits ignored
        step(1, 32'hABCD_0002, 0, "R3");
        step(0, 32'h0, 0, "R2");
        // R10: held request drains then stalls
        repeat (4) step(0, 32'h0, 1, "R10");
        step(1, 32'h0000_0005, 0, "R3");
        // R6: single decrement from nonzero
        step(0, 32'h0, 1, "R6");
        // R8: add two during decrement, net plus one
        step(1, 32'h0000_0002, 1, "R8");
        step(0, 32'h0, 0, "R8");
        // R5: saturation, alone and with a same-clock decrement
        step(1, 32'h0000_00FF, 0, "R5");
        step(1, 32'h0000_00FF, 0, "R5");
        step(1, 32'h0000_000A, 1, "R5");
        step(0, 32'h0, 0, "R5");
        // R10: full drain to a stall
        repeat (260) step(0, 32'h0, 1, "R10");
        step(0, 32'h0, 0, "R9");
        // R9: mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = {lfsr, lfsr ^ 16'h5A3C};
            if (lfsr[3:2] == 2'b00) d[7:0] = 8'h00;
            else if (lfsr[3:2] == 2'b01) d[7:0] = {6'b0, lfsr[9:8]};
            step(lfsr[0] & lfsr[5], d, lfsr[1] | lfsr[7], "R9");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule